// File: doc/BRIEF.md
# Dual-Channel 2x Halfband Interpolator

This block raises the sample rate of a pair of independent signed sample streams, called I and Q, by a factor of two. It runs on a single clock at the output rate. On alternate cycles it registers one new input word per channel, and it emits one output word per channel on every cycle. A symmetric 43-coefficient halfband low-pass filter suppresses the image that the rate doubling creates.

In that filter every second coefficient is zero and the middle coefficient equals the branch gain. The structure therefore splits into two polyphase branches. The first branch is a plain delayed copy of the input. The second is a 22-tap filter that adds symmetric sample pairs before it multiplies them by 11 fixed integer weights. The filtered branch is rounded and clamped back to the input word width. The output interleaves the two branches, filtered phase first.

The block sits between a baseband sample source and a converter that runs at twice the source rate. The source watches `in_take` and presents a new word whenever that pin is high.

Top module: `halfband_x2_interp`

## Requirements
- R1: The second word of each output pair is the input sample taken 10 input periods earlier, unchanged: for input sample x[n], the odd output is exactly x[n-10].
- R2: `in_take` is 0 while `rst` is high and 1 in the first cycle after `rst` falls. After that it toggles on every clock. The input words are captured at the rising edge that ends a cycle in which `in_take` is 1.
- R3: The first word of each output pair is floor((S + 8192) / 16384), where S = sum over i = 0..21 of a_i·x[n-i]. The weights a_0..a_10 are 10, -31, 69, -138, 248, -419, 678, -1083, 1776, -3282, 10364, and a_i = a_(21-i). Samples older than the last reset count as zero. All words are two's complement, 14 bits wide.
- R4: A filtered result above 8191 is output as 8191, and one below -8192 is output as -8192.
- R5: A constant full-scale input, either +8191 or -8192, is reproduced exactly on both output phases once the delay line holds only that value.
- R6: Reset is synchronous. It clears the delay lines and all pipeline and output registers, so both outputs read 0 in the cycle after reset and stay 0 while the inputs are 0.
- R7: A word captured at rising edge L produces its filtered output at edge L+3 and its delayed-copy output at edge L+4. The outputs change on every clock.
- R8: The I and Q channels do not interact: each output depends only on its own channel's input history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| in_take | output | 1 | High in the cycle whose closing edge captures the inputs |
| i_in | input | 14 | I-channel input sample, two's complement |
| q_in | input | 14 | Q-channel input sample, two's complement |
| i_out | output | 14 | I-channel output sample, two's complement |
| q_out | output | 14 | Q-channel output sample, two's complement |

## Verification
The assertions assume that the source drives a new word only in cycles where `in_take` is high and holds it steady across the capturing edge. They also assume that `rst` is held for at least one edge, so that the phase toggle and the centre-tap history start from cleared state. The stimulus meets these assumptions by changing the inputs only at falling edges on which `in_take` reads 1, and by holding reset for three cycles before every scenario. Each scenario then feeds zeros long enough to flush the 22-sample history, so every check sees a fully defined past.

// File: rtl/hbx2_pkg.sv
package hbx2_pkg;

  // coefficient word width and branch gain exponent
  localparam int CW      = 16;
  localparam int GAIN_SH = 14;
  localparam int NFOLD   = 11;

  // weight k counted from the outermost tap pair inward
  function automatic logic signed [CW-1:0] hb_coef(input int k);
    logic signed [CW-1:0] c;
    case (k)
      0:       c = 16'sd10;
      1:       c = -16'sd31;
      2:       c = 16'sd69;
      3:       c = -16'sd138;
      4:       c = 16'sd248;
      5:       c = -16'sd419;
      6:       c = 16'sd678;
      7:       c = -16'sd1083;
      8:       c = 16'sd1776;
      9:       c = -16'sd3282;
      10:      c = 16'sd10364;
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/hbx2_tapline.sv
module hbx2_tapline #(
  parameter int DW   = 14,
  parameter int NTAP = 22
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [DW-1:0]             din,
  output logic [NTAP-1:0][DW-1:0]   taps
);

  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= '0;
    end else if (load) begin
      taps <= {taps[NTAP-2:0], din};
    end
  end

  // R7: a load edge places the presented word at the head of the line
  p_load_head_r7: assert property (@(posedge clk) disable iff (rst)
    $past(load) |-> taps[0] == $past(din));

  // R7: the line is frozen on non-load edges
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(load)) |-> $stable(taps));

endmodule

// File: rtl/hbx2_polymac.sv
module hbx2_polymac #(
  parameter int DW   = 14,
  parameter int NTAP = 22,
  parameter int ACCW = 35
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NTAP-1:0][DW-1:0]   taps,
  output logic [ACCW-1:0]           acc
);
  import hbx2_pkg::*;

  localparam int NF = NTAP / 2;
  localparam int SW = DW + 1;

  logic [NF-1:0][SW-1:0] fold_q;
  logic signed [ACCW-1:0] acc_d;

  // fold symmetric sample pairs, one register per pair
  for (genvar k = 0; k < NF; k++) begin : g_fold
    always_ff @(posedge clk) begin
      if (rst) fold_q[k] <= '0;
      else     fold_q[k] <= SW'($signed(taps[k])) + SW'($signed(taps[NTAP-1-k]));
    end
  end

  always_comb begin
    acc_d = '0;
    for (int k = 0; k < NF; k++) begin
      acc_d = acc_d + ACCW'($signed(fold_q[k])) * ACCW'(hb_coef(k));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc_d;
  end

endmodule

// File: rtl/hbx2_merge.sv
module hbx2_merge #(
  parameter int DW   = 14,
  parameter int ACCW = 35,
  parameter int SH   = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_ctr,
  input  logic [ACCW-1:0] acc,
  input  logic [DW-1:0]   ctr_tap,
  output logic [DW-1:0]   y
);

  localparam int CDLY = 3;
  localparam logic signed [DW-1:0]   YMAX  = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0]   YMIN  = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [ACCW-1:0] HALF  = ACCW'(1) <<< (SH - 1);
  localparam logic signed [ACCW-1:0] MAXV  = ACCW'(YMAX);
  localparam logic signed [ACCW-1:0] MINV  = ACCW'(YMIN);

  function automatic logic signed [ACCW-1:0] round_up(input logic signed [ACCW-1:0] a);
    return (a + HALF) >>> SH;
  endfunction

  function automatic logic signed [DW-1:0] clamp(input logic signed [ACCW-1:0] r);
    if (r > MAXV)      return YMAX;
    else if (r < MINV) return YMIN;
    else               return r[DW-1:0];
  endfunction

  logic signed [ACCW-1:0] rnd_w;
  logic                   ovf_hi, ovf_lo;
  logic [DW-1:0]          filt_w;
  logic [CDLY-1:0][DW-1:0] cpipe;

  assign rnd_w  = round_up($signed(acc));
  assign ovf_hi = rnd_w > MAXV;
  assign ovf_lo = rnd_w < MINV;
  assign filt_w = clamp(rnd_w);

  // centre branch delay matched to fold + accumulate stages
  always_ff @(posedge clk) begin
    if (rst) cpipe <= '0;
    else     cpipe <= {cpipe[CDLY-2:0], ctr_tap};
  end

  always_ff @(posedge clk) begin
    if (rst)          y <= '0;
    else if (sel_ctr) y <= cpipe[CDLY-1];
    else              y <= filt_w;
  end

  p_sat_hi_r4: assert property (@(posedge clk) disable iff (rst)
    (ovf_hi && !sel_ctr) |=> y == YMAX);

  p_sat_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (ovf_lo && !sel_ctr) |=> y == YMIN);

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> y == '0);

endmodule

// File: rtl/halfband_x2_interp.sv
module halfband_x2_interp #(
  parameter int DW   = 14,
  parameter int NTAP = 22
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 in_take,
  input  logic signed [DW-1:0] i_in,
  input  logic signed [DW-1:0] q_in,
  output logic signed [DW-1:0] i_out,
  output logic signed [DW-1:0] q_out
);
  import hbx2_pkg::*;

  localparam int NCH  = 2;
  localparam int ACCW = DW + CW + $clog2(NTAP);
  localparam int CTR  = NTAP / 2 - 1;

  logic ph;
  logic [2:0] since_rst;
  logic [NCH-1:0][DW-1:0] ch_in, ch_out;
  logic [NCH-1:0][NTAP-1:0][DW-1:0] taps;
  logic [NCH-1:0][ACCW-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end

  // cycles since reset, used only to bound assertion history
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  assign in_take  = ph;
  assign ch_in[0] = i_in;
  assign ch_in[1] = q_in;
  assign i_out    = ch_out[0];
  assign q_out    = ch_out[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hbx2_tapline #(.DW(DW), .NTAP(NTAP)) u_line (
      .clk(clk), .rst(rst), .load(ph), .din(ch_in[c]), .taps(taps[c]));

    hbx2_polymac #(.DW(DW), .NTAP(NTAP), .ACCW(ACCW)) u_mac (
      .clk(clk), .rst(rst), .taps(taps[c]), .acc(acc[c]));

    hbx2_merge #(.DW(DW), .ACCW(ACCW), .SH(GAIN_SH)) u_merge (
      .clk(clk), .rst(rst), .sel_ctr(ph), .acc(acc[c]),
      .ctr_tap(taps[c][CTR]), .y(ch_out[c]));

    // R1: odd phase equals the centre tap seen four edges earlier
    p_centre_r1: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 3'd5 && $past(ph)) |-> ch_out[c] == $past(taps[c][CTR], 4));
  end

  p_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> in_take != $past(in_take));

endmodule

// File: tb/sim_halfband_x2_interp.sv
module sim_halfband_x2_interp;
  localparam int DW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_take;
  logic signed [DW-1:0] i_in = '0, q_in = '0;
  logic signed [DW-1:0] i_out, q_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int sx[2][128];
  int slen = 0;
  int hb_tbl[11] = '{10, -31, 69, -138, 248, -419, 678, -1083, 1776, -3282, 10364};

  always #4 clk = ~clk;

  halfband_x2_interp u0 (
    .clk(clk), .rst(rst), .in_take(in_take),
    .i_in(i_in), .q_in(q_in), .i_out(i_out), .q_out(q_out));

  function automatic int smp(int ch, int k);
    if (k < 0 || k >= slen) return 0;
    return sx[ch][k];
  endfunction

  // even output: floor division of the rounded convolution, then clamp
  function automatic int exp_filt(int ch, int m);
    longint s = 0;
    longint q;
    for (int i = 0; i < 22; i++)
      s += longint'(smp(ch, m - i)) * longint'(hb_tbl[(i < 11) ? i : 21 - i]);
    s += 8192;
    q = s / 16384;
    if (s < 0 && (s % 16384) != 0) q -= 1;
    if (q > 8191) q = 8191;
    if (q < -8192) q = -8192;
    return int'(q);
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    i_in = '0; q_in = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R6", "i_out after reset", int'(i_out), 0);
    chk("R6", "q_out after reset", int'(q_out), 0);
    chk("R2", "in_take after reset", int'(in_take), 0);
  endtask

  // drives the loaded pattern plus zero flush, checking every output word
  task automatic run_stream(string req, int n);
    slen = n;
    for (int j = 0; j < n + 26; j++) begin
      @(negedge clk);
      while (!in_take) @(negedge clk);
      chk({req, " R7"}, $sformatf("I even j=%0d", j), int'(i_out), exp_filt(0, j - 2));
      chk({req, " R8"}, $sformatf("Q even j=%0d", j), int'(q_out), exp_filt(1, j - 2));
      i_in = DW'(smp(0, j));
      q_in = DW'(smp(1, j));
      @(negedge clk);
      chk("R1", $sformatf("I odd j=%0d", j), int'(i_out), smp(0, j - 12));
      chk("R1", $sformatf("Q odd j=%0d", j), int'(q_out), smp(1, j - 12));
    end
    i_in = '0; q_in = '0;
  endtask

  task automatic t_phase();  // R2
    do_reset();
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R2", $sformatf("in_take cycle %0d", k), int'(in_take), (k % 2 == 0) ? 1 : 0);
    end
  endtask

  task automatic t_zero();  // R6
    do_reset();
    for (int k = 0; k < 8; k++) begin sx[0][k] = 0; sx[1][k] = 0; end
    run_stream("R6", 8);
  endtask

  task automatic t_impulse();  // R3, R8: different sizes and timing per channel
    do_reset();
    for (int k = 0; k < 6; k++) begin sx[0][k] = 0; sx[1][k] = 0; end
    sx[0][0] = 8191;
    sx[1][3] = -8192;
    run_stream("R3", 6);
    do_reset();
    for (int k = 0; k < 6; k++) begin sx[0][k] = 0; sx[1][k] = 0; end
    sx[0][2] = 4096;
    run_stream("R3", 6);
  endtask

  task automatic t_dc();  // R5
    do_reset();
    for (int k = 0; k < 40; k++) begin sx[0][k] = 8191; sx[1][k] = -8192; end
    run_stream("R5", 40);
  endtask

  task automatic t_alt();  // R3
    do_reset();
    for (int k = 0; k < 40; k++) begin
      sx[0][k] = (k % 2 == 0) ? 8191 : -8192;
      sx[1][k] = (k % 2 == 0) ? -8192 : 8191;
    end
    run_stream("R3", 40);
  endtask

  task automatic t_sat();  // R4: inputs aligned with weight signs
    do_reset();
    for (int k = 0; k < 22; k++) begin
      int w = hb_tbl[(k < 11) ? k : 21 - k];
      sx[0][k] = (w > 0) ? 8191 : -8192;
      sx[1][k] = (w > 0) ? -8192 : 8191;
    end
    run_stream("R4", 22);
    chk("R4", "I clamp high", exp_filt(0, 21), 8191);
    chk("R4", "Q clamp low", exp_filt(1, 21), -8192);
  endtask

  task automatic t_mixed();  // R3, R8: unrelated pseudo-random streams
    int seed = 12345;
    do_reset();
    for (int k = 0; k < 60; k++) begin
      seed = seed * 1103515245 + 12345;
      sx[0][k] = ((seed >>> 8) & 16383) - 8192;
      seed = seed * 1103515245 + 12345;
      sx[1][k] = ((seed >>> 8) & 16383) - 8192;
    end
    run_stream("R3", 60);
  endtask

  initial begin
    t_phase();
    t_zero();
    t_impulse();
    t_dc();
    t_alt();
    t_sat();
    t_mixed();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule